// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control state of a processor core as a bank of 64-bit registers selected by a 6-bit index. It has one combinational read port and one clocked write port. Each index follows its own write policy. Scratch registers take the whole word. Several registers keep only a fixed bit pattern. Two summary registers clear on any write. A cycle-count register mixes its stored upper half with a live counter. Read-only indices refuse writes, and write-only control indices refuse reads. Unknown indices refuse both.

A write to a control-only index stores nothing. Instead it raises a one-cycle side-effect strobe that carries the index, so that neighbouring logic (flush, invalidate, interrupt-clear engines) can act on it. A speculative qualifier on the write port makes a write vanish: nothing changes, no fault is raised and no strobe is produced. Faults are combinational and describe the access presented in the same cycle.

Top module: `priv_csr_bank`

## Requirements
- R1: After reset every register reads zero without a fault, and the side-effect strobe is low.
- R2: Indices 0 to 7 are scratch registers that store the full 64-bit write value.
- R3: Index 8 (exception return address) stores the written value with bit 1 forced to zero.
- R4: Masked stores: indices 9 and 10 keep bits [3:0]; index 11 keeps bits [4:0]; indices 12 and 13 keep only the bits in 0x18; index 14 keeps only the bits in 0x7FFF0. All other bits read zero.
- R5: Indices 15 and 16 (exception summary and mask) become zero on a write of any value.
- R6: Indices 18 to 21 are read-only. They read zero without a fault. A write to them raises wr_fault in the same cycle and changes nothing.
- R7: Indices 22 to 26 are write-only controls. A read raises rd_fault and returns zero. An accepted write raises no fault, and in the following cycle it drives side_stb high for exactly one cycle with side_idx equal to the written index.
- R8: Indices 27 to 63 are unknown: reads fault and return zero, and writes fault.
- R9: Index 17 (cycle count) reads as the stored bits [63:32] over the low 32 bits of a free-running counter that advances by one every clock after reset.
- R10: A write presented with wr_spec high changes no register, raises no fault and produces no strobe.
- R11: Read data and rd_fault depend combinationally on rd_idx. A write takes effect at the clock edge, so a read of the same index in the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, zero on a faulting read |
| rd_fault | output | 1 | Illegal read of the presented index |
| wr_en | input | 1 | Write request |
| wr_spec | input | 1 | Marks the write as speculative, which suppresses it |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write value |
| wr_fault | output | 1 | Illegal non-speculative write of the presented index |
| side_stb | output | 1 | One-cycle strobe after an accepted control write |
| side_idx | output | 6 | Index that caused the strobe |

## Verification
A read and a write of the same index can fall in the same cycle. The bench provokes this by driving both ports at one scratch index together. In that cycle it expects the old value, and in the next cycle it expects the new one. A read on one port and a control write with its strobe can also overlap. The bench reads a masked register while the strobe from an earlier control write is visible, and it checks the strobe index and the read data independently against queued expectations.

// File: rtl/priv_csr_bank.sv
module priv_csr_bank #(
  parameter int XLEN        = 64,
  parameter int IDX_W       = 6,
  parameter int NUM_SCRATCH = 8,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             rd_fault,
  input  logic             wr_en,
  input  logic             wr_spec,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output logic             wr_fault,
  output logic             side_stb,
  output logic [IDX_W-1:0] side_idx
);

  localparam int I_EXC  = NUM_SCRATCH;
  localparam int I_TRQ  = I_EXC + 1;
  localparam int I_TEN  = I_EXC + 2;
  localparam int I_IPL  = I_EXC + 3;
  localparam int I_MDI  = I_EXC + 4;
  localparam int I_MDD  = I_EXC + 5;
  localparam int I_SWI  = I_EXC + 6;
  localparam int I_ESUM = I_EXC + 7;
  localparam int I_EMSK = I_EXC + 8;
  localparam int I_CYC  = I_EXC + 9;
  localparam int N_ST   = I_CYC + 1;
  localparam int RO_LO  = N_ST;
  localparam int RO_HI  = RO_LO + 3;
  localparam int WO_LO  = RO_HI + 1;
  localparam int WO_HI  = WO_LO + 4;

  function automatic logic [XLEN-1:0] keep_mask(input int i);
    case (i)
      I_EXC:          keep_mask = ~XLEN'(2);
      I_TRQ, I_TEN:   keep_mask = XLEN'(64'hF);
      I_IPL:          keep_mask = XLEN'(64'h1F);
      I_MDI, I_MDD:   keep_mask = XLEN'(64'h18);
      I_SWI:          keep_mask = XLEN'(64'h7FFF0);
      I_ESUM, I_EMSK: keep_mask = '0;
      default:        keep_mask = '1;
    endcase
  endfunction

  logic [XLEN-1:0]  store [N_ST];
  logic [CNT_W-1:0] tick;

  wire wr_go = wr_en & ~wr_spec;
  wire rd_st = rd_idx < IDX_W'(N_ST);
  wire rd_ro = (rd_idx >= IDX_W'(RO_LO)) && (rd_idx <= IDX_W'(RO_HI));
  wire wr_st = wr_idx < IDX_W'(N_ST);
  wire wr_wo = (wr_idx >= IDX_W'(WO_LO)) && (wr_idx <= IDX_W'(WO_HI));

  genvar g;
  generate
    for (g = 0; g < N_ST; g++) begin : g_reg
      localparam logic [XLEN-1:0] KEEP = keep_mask(g);
      always_ff @(posedge clk) begin
        if (!rst_n)
          store[g] <= '0;
        else if (wr_go && wr_idx == IDX_W'(g))
          store[g] <= wr_data & KEEP;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick + 1'b1;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_ST; k++)
      if (rd_idx == IDX_W'(k)) rd_data = store[k];
    if (rd_idx == IDX_W'(I_CYC))
      rd_data = {store[I_CYC][XLEN-1:CNT_W], tick};
  end

  assign rd_fault = ~(rd_st | rd_ro);
  assign wr_fault = wr_go & ~(wr_st | wr_wo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side_stb <= 1'b0;
      side_idx <= '0;
    end else begin
      side_stb <= wr_go & wr_wo;
      side_idx <= (wr_go & wr_wo) ? wr_idx : '0;
    end
  end

endmodule

// File: rtl/priv_csr_bank_chk.sv
module priv_csr_bank_chk #(
  parameter int XLEN        = 64,
  parameter int IDX_W       = 6,
  parameter int NUM_SCRATCH = 8,
  parameter int CNT_W       = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rd_idx,
  input logic [XLEN-1:0]  rd_data,
  input logic             rd_fault,
  input logic             wr_en,
  input logic             wr_spec,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_fault,
  input logic             side_stb,
  input logic [IDX_W-1:0] side_idx
);
  localparam int I_EXC = NUM_SCRATCH;
  localparam int I_IPL = NUM_SCRATCH + 3;
  localparam int I_CYC = NUM_SCRATCH + 9;

  p_spec_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_spec) |-> !wr_fault);

  p_spec_nostb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_spec) |=> !side_stb);

  p_stb_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    side_stb |-> ($past(wr_en && !wr_spec) && side_idx == $past(wr_idx)));

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> rd_data == '0);

  p_exc_bit1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IDX_W'(I_EXC)) |-> !rd_data[1]);

  p_ipl_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IDX_W'(I_IPL)) |-> rd_data[XLEN-1:5] == '0);

  p_cyc_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rd_idx == IDX_W'(I_CYC) && $past(rd_idx == IDX_W'(I_CYC)))
      |-> rd_data[CNT_W-1:0] == CNT_W'($past(rd_data[CNT_W-1:0]) + 1'b1));

  p_wfault_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> (wr_en && !wr_spec));

endmodule

bind priv_csr_bank priv_csr_bank_chk #(
  .XLEN(XLEN), .IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/priv_csr_bank_test.sv
`timescale 1ns/1ps
module priv_csr_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        rd_fault;
  logic        wr_en = 0;
  logic        wr_spec = 0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_fault;
  logic        side_stb;
  logic [5:0]  side_idx;

  priv_csr_bank uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    logic [63:0] msk;
    logic        f;
    string       tag;
  } item_t;

  item_t q[$];
  item_t mit;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      mit = q.pop_front();
      checks++;
      case (mit.kind)
        0: if (((rd_data & mit.msk) !== mit.exp) || (rd_fault !== mit.f)) begin
             fails++;
             $display("FAIL %s read: data=%h fault=%b expected data=%h fault=%b",
                      mit.tag, rd_data & mit.msk, rd_fault, mit.exp, mit.f);
           end
        1: if (wr_fault !== mit.f) begin
             fails++;
             $display("FAIL %s wr_fault=%b expected %b", mit.tag, wr_fault, mit.f);
           end
        default: if ((side_stb !== mit.f) || (mit.f && side_idx !== mit.exp[5:0])) begin
             fails++;
             $display("FAIL %s strobe=%b idx=%0d expected strobe=%b idx=%0d",
                      mit.tag, side_stb, side_idx, mit.f, mit.exp[5:0]);
           end
      endcase
    end
  end

  task automatic push(int kind, logic [63:0] exp, logic f, string tag,
                      logic [63:0] msk = '1);
    item_t it;
    it.kind = kind; it.exp = exp; it.msk = msk; it.f = f; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(logic [5:0] idx, logic [63:0] exp, logic f, string tag,
                    logic [63:0] msk = '1);
    @(posedge clk); #1;
    rd_idx = idx;
    push(0, exp, f, tag, msk);
  endtask

  task automatic wr(logic [5:0] idx, logic [63:0] d, logic spec, logic expf,
                    logic stb, string tag);
    @(posedge clk); #1;
    wr_en = 1; wr_idx = idx; wr_data = d; wr_spec = spec;
    push(1, 64'd0, expf, tag);
    @(posedge clk); #1;
    wr_en = 0; wr_spec = 0;
    push(2, {58'd0, idx}, stb, tag);
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] ONES = '1;

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(side_stb == 1'b0, "R1 strobe low", {63'd0, side_stb}, 64'd0);
    for (int i = 0; i < 17; i++) rd(i[5:0], 64'd0, 1'b0, "R1 reset zero");
    rd(6'd17, 64'd0, 1'b0, "R1 cycle upper zero", 64'hFFFFFFFF_00000000);

    // R2: scratch full write
    wr(6'd3, 64'hA5A5_5A5A_0123_4567, 1'b0, 1'b0, 1'b0, "R2 write");
    rd(6'd3, 64'hA5A5_5A5A_0123_4567, 1'b0, "R2 readback");
    wr(6'd0, ONES, 1'b0, 1'b0, 1'b0, "R2 write idx0");
    rd(6'd0, ONES, 1'b0, "R2 readback idx0");

    // R11: same-cycle read and write of one index
    @(posedge clk); #1;
    wr_en = 1; wr_idx = 6'd5; wr_data = 64'hCAFE_F00D_0000_0001; rd_idx = 6'd5;
    push(1, 64'd0, 1'b0, "R11 write");
    push(0, 64'd0, 1'b0, "R11 old value in write cycle");
    @(posedge clk); #1;
    wr_en = 0;
    push(2, 64'd5, 1'b0, "R11 no strobe");
    push(0, 64'hCAFE_F00D_0000_0001, 1'b0, "R11 new value after edge");

    // R3
    wr(6'd8, ONES, 1'b0, 1'b0, 1'b0, "R3 write");
    rd(6'd8, ~64'd2, 1'b0, "R3 bit1 cleared");

    // R4
    wr(6'd9,  ONES, 1'b0, 1'b0, 1'b0, "R4 w9");
    rd(6'd9,  64'hF, 1'b0, "R4 idx9");
    wr(6'd10, ONES, 1'b0, 1'b0, 1'b0, "R4 w10");
    rd(6'd10, 64'hF, 1'b0, "R4 idx10");
    wr(6'd11, ONES, 1'b0, 1'b0, 1'b0, "R4 w11");
    rd(6'd11, 64'h1F, 1'b0, "R4 idx11");
    wr(6'd12, ONES, 1'b0, 1'b0, 1'b0, "R4 w12");
    rd(6'd12, 64'h18, 1'b0, "R4 idx12");
    wr(6'd13, 64'h0F, 1'b0, 1'b0, 1'b0, "R4 w13");
    rd(6'd13, 64'h08, 1'b0, "R4 idx13");
    wr(6'd14, ONES, 1'b0, 1'b0, 1'b0, "R4 w14");
    rd(6'd14, 64'h7FFF0, 1'b0, "R4 idx14");

    // R5
    wr(6'd15, ONES, 1'b0, 1'b0, 1'b0, "R5 w15");
    rd(6'd15, 64'd0, 1'b0, "R5 idx15 clear");
    wr(6'd16, 64'h1234, 1'b0, 1'b0, 1'b0, "R5 w16");
    rd(6'd16, 64'd0, 1'b0, "R5 idx16 clear");

    // R6
    wr(6'd18, ONES, 1'b0, 1'b1, 1'b0, "R6 write faults");
    rd(6'd18, 64'd0, 1'b0, "R6 read ok unchanged");
    wr(6'd21, ONES, 1'b0, 1'b1, 1'b0, "R6 write idx21 faults");
    rd(6'd21, 64'd0, 1'b0, "R6 idx21 unchanged");

    // R7 with an overlapping read of a masked register
    @(posedge clk); #1;
    wr_en = 1; wr_idx = 6'd23; wr_data = 64'h55;
    push(1, 64'd0, 1'b0, "R7 control write ok");
    @(posedge clk); #1;
    wr_en = 0; rd_idx = 6'd11;
    push(2, 64'd23, 1'b1, "R7 strobe idx23");
    push(0, 64'h1F, 1'b0, "R7 overlap read idx11");
    @(posedge clk); #1;
    push(2, 64'd0, 1'b0, "R7 strobe one cycle");
    rd(6'd23, 64'd0, 1'b1, "R7 read faults");
    wr(6'd26, 64'd1, 1'b0, 1'b0, 1'b1, "R7 strobe idx26");
    rd(6'd22, 64'd0, 1'b1, "R7 read idx22 faults");

    // R8
    wr(6'd40, ONES, 1'b0, 1'b1, 1'b0, "R8 write faults");
    rd(6'd40, 64'd0, 1'b1, "R8 read faults");
    rd(6'd27, 64'd0, 1'b1, "R8 idx27");
    rd(6'd63, 64'd0, 1'b1, "R8 idx63");

    // R10
    wr(6'd3, 64'h1111, 1'b1, 1'b0, 1'b0, "R10 spec write no fault");
    rd(6'd3, 64'hA5A5_5A5A_0123_4567, 1'b0, "R10 unchanged");
    wr(6'd22, 64'h1, 1'b1, 1'b0, 1'b0, "R10 spec control no strobe");
    wr(6'd40, 64'h1, 1'b1, 1'b0, 1'b0, "R10 spec unknown no fault");

    // R9
    wr(6'd17, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0, 1'b0, "R9 write");
    rd(6'd17, 64'hDEAD_BEEF_0000_0000, 1'b0, "R9 upper half", 64'hFFFFFFFF_00000000);
    @(negedge clk);
    a = rd_data[31:0];
    @(negedge clk);
    b = rd_data[31:0];
    chk(b == a + 32'd1, "R9 counter step", {32'd0, b}, {32'd0, a + 32'd1});
    repeat (7) @(negedge clk);
    a = rd_data[31:0];
    chk(a == b + 32'd7, "R9 counter span", {32'd0, a}, {32'd0, b + 32'd7});

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule